// File: doc/BRIEF.md
# Debug Host Command and Readback Port

This block is the target-side half of a debug controller. A small host controller talks to it through two narrow parallel ports. The first is a six-bit command port. Five of its bits hold an opcode and the sixth is a strobe. Each rising edge of the strobe carries out the opcode once. The second port is a six-bit select, which chooses one byte of internal or neighbouring state to appear on an eight-bit read port.

The opcodes do several things. Some set the single-step, breakpoint and CPU-reset control levels. Some emit one-cycle pulses to neighbouring logic: a step, an event pop, an event-queue clear, and one bit of breakpoint configuration. One shifts a single bit into a shared address/data register. The rest launch memory or IO bus cycles on a simple request/acknowledge master, optionally advancing the address afterwards.

The block also keeps a 24-bit cycle counter that runs while the CPU runs. Through the read mux it exposes the last instruction address, the captured read data, the cycle counter and the nine bytes at the head of the event queue. The CPU core, the breakpoint comparators and the event queue storage are outside this block.

Top module: `dbg_host_port`

## Requirements
- R1: An opcode is carried out exactly once for each 0-to-1 transition of command bit 5, however long the strobe stays high. The opcode is taken from bits 4..0 in the cycle in which the synchronised edge is seen.
- R2: Opcodes 0x00/0x01 set `step_mode` to opcode bit 0. Opcodes 0x02/0x03 set `brk_enable` the same way. Opcodes 0x06/0x07 set `cpu_reset` the same way. Each level holds until it is changed again.
- R3: Opcode 0x08 gives one single-cycle `step_pulse`. Opcode 0x09 gives one `evt_pop`. Opcode 0x0A gives one `evt_clear`. Opcodes 0x04/0x05 give one `brk_shift_en` pulse with `brk_shift_bit` equal to opcode bit 0.
- R4: Opcodes 0x0C/0x0D shift opcode bit 0 into a 24-bit register, LSB first. After the host shifts eight data bits and then sixteen address bits, `bus_wdata` shows the data byte and `bus_addr` shows the address.
- R5: Opcodes 0x10 to 0x17 start one bus cycle. In the opcode, bit 0 selects auto-increment, bit 1 selects write and bit 2 selects IO space. `bus_req` and the cycle's address, data and kind stay steady until `bus_ack` is seen. While a cycle is outstanding, shift and bus opcodes are ignored.
- R6: A read cycle captures `bus_rdata` at the acknowledge, and the captured byte reads back at offset 2.
- R7: After an auto-increment cycle completes, the address goes up by one, wrapping from 0xFFFF to 0x0000. Without auto-increment, the address is left unchanged.
- R8: Offsets 0 and 1 return the low and high bytes of `last_iaddr`. Offsets 4, 5 and 3 return the low, middle and high bytes of the cycle counter.
- R9: The cycle counter advances by one on each clock while `cpu_running` is high, and holds otherwise.
- R10: Offset 6+k, for k from 0 to 8, returns byte k (bits 8k+7..8k) of `evt_head`.
- R11: Opcodes 0x0B, 0x0E, 0x0F and 0x18 to 0x1F change no output and no state. Offset 15 and offsets 16 to 63 return 0x00.
- R12: After reset, all outputs are low, the cycle counter is zero and the captured read byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_port | input | 6 | Bit 5 strobe, bits 4..0 opcode |
| rd_sel | input | 6 | Readback byte select |
| rd_byte | output | 8 | Selected readback byte |
| cpu_running | input | 1 | High while the CPU executes; gates the cycle counter |
| last_iaddr | input | 16 | Address of the last executed instruction |
| evt_head | input | 72 | Word at the head of the event queue |
| step_mode | output | 1 | Single-step enable level |
| brk_enable | output | 1 | Breakpoint enable level |
| cpu_reset | output | 1 | CPU reset level |
| step_pulse | output | 1 | One-cycle step request |
| evt_pop | output | 1 | One-cycle event queue pop |
| evt_clear | output | 1 | One-cycle event queue clear |
| brk_shift_en | output | 1 | One-cycle breakpoint shift strobe |
| brk_shift_bit | output | 1 | Bit to shift into the breakpoint chain |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_wr | output | 1 | Cycle is a write |
| bus_io | output | 1 | Cycle targets IO space |
| bus_addr | output | 16 | Cycle address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Cycle completion, sampled while `bus_req` is high |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |

## Verification
The assertions rely on three things about the environment. The opcode bits hold still around each strobe edge. `bus_ack` is raised only while `bus_req` is high. Every request is eventually acknowledged. The stimulus honours all three. It changes the opcode only while the strobe is low and two cycles before the strobe rises. Its bus responder raises the acknowledge for one cycle only in reply to an open request, after a programmable delay. That delay is stretched once on purpose, so that opcodes arrive while a cycle is outstanding.

// File: rtl/dbg_host_port.sv
module dbg_host_port #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 24,
  parameter int EVT_BYTES = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [5:0]             cmd_port,
  input  logic [5:0]             rd_sel,
  output logic [7:0]             rd_byte,
  input  logic                   cpu_running,
  input  logic [ADDR_W-1:0]      last_iaddr,
  input  logic [8*EVT_BYTES-1:0] evt_head,
  output logic                   step_mode,
  output logic                   brk_enable,
  output logic                   cpu_reset,
  output logic                   step_pulse,
  output logic                   evt_pop,
  output logic                   evt_clear,
  output logic                   brk_shift_en,
  output logic                   brk_shift_bit,
  output logic                   bus_req,
  output logic                   bus_wr,
  output logic                   bus_io,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [7:0]             bus_wdata,
  input  logic                   bus_ack,
  input  logic [7:0]             bus_rdata
);
  localparam int SR_W    = ADDR_W + 8;
  localparam int EVT_OFS = 6;

  logic [2:0]      stb_q;
  logic [SR_W-1:0] sr;
  logic            inc_q;
  logic [7:0]      rd_q;
  logic [CNT_W-1:0] cyc;

  wire       fire = stb_q[1] & ~stb_q[2];
  wire [4:0] op   = cmd_port[4:0];

  assign bus_addr  = sr[SR_W-1:8];
  assign bus_wdata = sr[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_q <= '0;
    else        stb_q <= {stb_q[1:0], cmd_port[5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_mode <= 1'b0; brk_enable <= 1'b0; cpu_reset <= 1'b0;
      step_pulse <= 1'b0; evt_pop <= 1'b0; evt_clear <= 1'b0;
      brk_shift_en <= 1'b0; brk_shift_bit <= 1'b0;
      bus_req <= 1'b0; bus_wr <= 1'b0; bus_io <= 1'b0; inc_q <= 1'b0;
      sr <= '0; rd_q <= '0;
    end else begin
      step_pulse <= 1'b0; evt_pop <= 1'b0; evt_clear <= 1'b0; brk_shift_en <= 1'b0;
      if (fire) begin
        case (op)
          5'h00, 5'h01: step_mode  <= op[0];
          5'h02, 5'h03: brk_enable <= op[0];
          5'h04, 5'h05: begin brk_shift_en <= 1'b1; brk_shift_bit <= op[0]; end
          5'h06, 5'h07: cpu_reset  <= op[0];
          5'h08:        step_pulse <= 1'b1;
          5'h09:        evt_pop    <= 1'b1;
          5'h0A:        evt_clear  <= 1'b1;
          5'h0C, 5'h0D: if (!bus_req) sr <= {op[0], sr[SR_W-1:1]};
          5'h10, 5'h11, 5'h12, 5'h13,
          5'h14, 5'h15, 5'h16, 5'h17:
            if (!bus_req) begin
              bus_req <= 1'b1; inc_q <= op[0]; bus_wr <= op[1]; bus_io <= op[2];
            end
          default: ;
        endcase
      end
      if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_wr) rd_q <= bus_rdata;
        if (inc_q)   sr[SR_W-1:8] <= sr[SR_W-1:8] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cyc <= '0;
    else if (cpu_running) cyc <= cyc + 1'b1;

  always_comb begin
    rd_byte = 8'h00;
    case (rd_sel)
      6'd0: rd_byte = last_iaddr[7:0];
      6'd1: rd_byte = last_iaddr[15:8];
      6'd2: rd_byte = rd_q;
      6'd3: rd_byte = cyc[23:16];
      6'd4: rd_byte = cyc[7:0];
      6'd5: rd_byte = cyc[15:8];
      default:
        for (int k = 0; k < EVT_BYTES; k++)
          if (rd_sel == 6'(k + EVT_OFS)) rd_byte = evt_head[8*k +: 8];
    endcase
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_wr) && $stable(bus_io));
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_pulse, evt_pop, evt_clear, brk_shift_en}));
  p_pulse_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_running |=> $stable(cyc));
  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && inc_q |=> bus_addr == ADDR_W'($past(bus_addr) + 1'b1));
  p_no_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && !inc_q |=> $stable(bus_addr));
  p_levels_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q[1] |=> $stable(step_mode) && $stable(brk_enable) && $stable(cpu_reset));
endmodule

// File: tb/dbg_host_port_test.sv
module dbg_host_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cmd_port = '0, rd_sel = '0;
  logic [7:0] rd_byte;
  logic cpu_running = 1'b0;
  logic [15:0] last_iaddr = 16'hBEEF;
  logic [71:0] evt_head = 72'hA1_B2_C3_D4_E5_F6_07_18_29;
  logic step_mode, brk_enable, cpu_reset, step_pulse, evt_pop, evt_clear;
  logic brk_shift_en, brk_shift_bit, bus_req, bus_wr, bus_io;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;

  int errors = 0, checks = 0;
  int n_step = 0, n_pop = 0, n_clr = 0, n_bsh = 0, n_req = 0;
  int ack_delay = 2;
  logic [25:0] exp_q[$];

  always #5 clk = ~clk;

  dbg_host_port uut (.*);

  function automatic logic [7:0] mem_of(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (step_pulse) n_step++;
    if (evt_pop) n_pop++;
    if (evt_clear) n_clr++;
    if (brk_shift_en) n_bsh++;
  end

  initial forever begin
    @(negedge clk);
    if (bus_req && !bus_ack) begin
      n_req++;
      repeat (ack_delay - 1) @(negedge clk);
      if (exp_q.size() == 0) begin
        chk("R5 unexpected bus cycle", {6'b0, bus_wr, bus_io, bus_addr, bus_wdata}, 32'hFFFFFFFF);
      end else begin
        logic [25:0] e;
        e = exp_q.pop_front();
        chk("R5 bus cycle", {6'b0, bus_wr, bus_io, bus_addr, (bus_wr ? bus_wdata : 8'h00)},
            {6'b0, e});
      end
      bus_rdata = mem_of(bus_addr);
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
  end

  task automatic send(logic [4:0] op, int hold = 6, bit wait_idle = 1);
    @(negedge clk);
    cmd_port = {1'b0, op};
    repeat (2) @(negedge clk);
    cmd_port[5] = 1'b1;
    repeat (hold) @(negedge clk);
    cmd_port[5] = 1'b0;
    repeat (3) @(negedge clk);
    if (wait_idle) begin
      while (bus_req || bus_ack) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic shift_in(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) send(5'h0C | 5'(v[i]));
  endtask

  task automatic load(logic [15:0] a, logic [7:0] d);
    shift_in({8'h00, d}, 8);
    shift_in(a, 16);
  endtask

  task automatic bus_op(logic [4:0] op);
    exp_q.push_back({op[1], op[2], bus_addr, (op[1] ? bus_wdata : 8'h00)});
    send(op);
  endtask

  task automatic rd(logic [5:0] s, output logic [7:0] v);
    @(negedge clk);
    rd_sel = s;
    #1 v = rd_byte;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] a0;
    int s0, p0, c0, b0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 levels", {step_mode, brk_enable, cpu_reset, bus_req, bus_wr, bus_io}, 0);
    chk("R12 pulses", {step_pulse, evt_pop, evt_clear, brk_shift_en, brk_shift_bit}, 0);
    chk("R12 addr/data", {bus_addr, bus_wdata}, 0);
    rd(6'd2, v); chk("R12 read byte", v, 0);
    rd(6'd4, v); chk("R12 counter", v, 0);

    // R9 counter runs 300 cycles
    @(negedge clk); cpu_running = 1'b1;
    repeat (300) @(negedge clk);
    cpu_running = 1'b0;
    repeat (20) @(negedge clk);
    rd(6'd4, v); chk("R8 R9 counter low", v, 8'h2C);
    rd(6'd5, v); chk("R8 R9 counter mid", v, 8'h01);
    rd(6'd3, v); chk("R8 R9 counter high", v, 8'h00);

    // R8 instruction address, R10 event head, R11 unused offsets
    rd(6'd0, v); chk("R8 iaddr low", v, 8'hEF);
    rd(6'd1, v); chk("R8 iaddr high", v, 8'hBE);
    for (int k = 0; k < 9; k++) begin
      rd(6'(6 + k), v); chk("R10 event byte", v, evt_head[8*k +: 8]);
    end
    rd(6'd15, v); chk("R11 offset 15", v, 0);
    rd(6'd16, v); chk("R11 offset 16", v, 0);
    rd(6'd63, v); chk("R11 offset 63", v, 0);

    // R2 levels
    send(5'h01); chk("R2 step_mode on", step_mode, 1);
    send(5'h03); chk("R2 brk_enable on", brk_enable, 1);
    send(5'h07); chk("R2 cpu_reset on", cpu_reset, 1);
    send(5'h00); chk("R2 step_mode off", step_mode, 0);
    send(5'h06); chk("R2 cpu_reset off", {brk_enable, cpu_reset}, 2'b10);

    // R1 long strobe, R3 pulses
    s0 = n_step; send(5'h08, 40); chk("R1 one step per edge", n_step - s0, 1);
    send(5'h08); send(5'h08); chk("R3 two steps", n_step - s0, 3);
    p0 = n_pop; send(5'h09); chk("R3 pop", n_pop - p0, 1);
    c0 = n_clr; send(5'h0A); chk("R3 clear", n_clr - c0, 1);
    b0 = n_bsh; send(5'h05);
    chk("R3 brk shift", {n_bsh - b0, 31'(brk_shift_bit)}, {32'd1, 31'd1});
    send(5'h04); chk("R3 brk shift bit 0", brk_shift_bit, 0);

    // R4 shift load
    load(16'h12F0, 8'h3C);
    chk("R4 address", bus_addr, 16'h12F0);
    chk("R4 data", bus_wdata, 8'h3C);

    // R5 R6 plain memory read
    bus_op(5'h10);
    rd(6'd2, v); chk("R6 read data", v, mem_of(16'h12F0));
    chk("R7 no increment", bus_addr, 16'h12F0);

    // R5 R7 write with increment
    bus_op(5'h13); chk("R7 write inc", bus_addr, 16'h12F1);
    // IO read with increment
    bus_op(5'h15);
    rd(6'd2, v); chk("R6 io read data", v, mem_of(16'h12F1));
    chk("R7 io inc", bus_addr, 16'h12F2);
    bus_op(5'h16); chk("R7 io write no inc", bus_addr, 16'h12F2);

    // R7 wrap
    load(16'hFFFF, 8'hC5);
    bus_op(5'h11); chk("R7 wrap", bus_addr, 16'h0000);

    // R5 commands ignored while a cycle is open
    load(16'h4321, 8'h99);
    ack_delay = 60;
    r0 = n_req;
    exp_q.push_back({1'b1, 1'b0, 16'h4321, 8'h99});
    send(5'h12, 6, 0);
    send(5'h0D, 6, 0);
    send(5'h10, 6, 0);
    chk("R5 shift ignored while busy", {bus_req, bus_addr, bus_wdata}, {1'b1, 16'h4321, 8'h99});
    while (bus_req || bus_ack) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R5 single cycle while busy", n_req - r0, 1);
    ack_delay = 2;

    // R11 unused opcodes
    send(5'h01);
    a0 = bus_addr;
    s0 = n_step + n_pop + n_clr + n_bsh; r0 = n_req;
    send(5'h0B); send(5'h0E); send(5'h0F); send(5'h18); send(5'h1F);
    chk("R11 no pulses", n_step + n_pop + n_clr + n_bsh - s0, 0);
    chk("R11 no bus", n_req - r0, 0);
    chk("R11 levels kept", {step_mode, brk_enable, cpu_reset}, 3'b110);
    chk("R11 addr/data kept", {bus_addr, bus_wdata}, {a0, 8'h99});

    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule